// File: doc/BRIEF.md
# Quadrature-Sampled AM Envelope Detector

This block recovers the amplitude envelope of an AM subcarrier whose samples arrive at exactly four times the carrier frequency. At that rate two neighbouring samples are a quarter period apart, so they behave as an in-phase and quadrature pair. The envelope is then the root of the sum of their squares, and no low-pass filter is needed after detection.

Samples enter as 8-bit companded codes with a valid strobe. The block drops each code's sign, because only squared values count. It pairs the 7-bit magnitude of the new sample with the magnitude of the sample accepted before it. The concatenated 14 bits index a function of both magnitudes: the root of the sum of their squared linear values, scaled to a 12-bit unsigned envelope. That function is built at elaboration, and a parameter selects its form. One form is a full precomputed table with 16384 entries. The other is a factored datapath with the same result, made of two expanders, an adder and a root stage.

Each accepted sample yields one envelope sample two clocks later, except the first sample after reset.

Top module: `env_lut_detector`

## Requirements
- R1: Bit 7 of each input code is a sign bit and has no effect on any result; two codes that differ only in bit 7 give identical envelopes.
- R2: A magnitude has exponent e in bits 6:4 and mantissa m in bits 3:0. It decodes to the linear value ((2*m + 33) << e) - 33, so magnitude 0 decodes to 0 and magnitude 0x7F decodes to 8031.
- R3: For each accepted sample after the first, env_o equals floor(sqrt(a*a + b*b)) >> 2. Here a and b are the decoded magnitudes of the current sample and the previously accepted sample, and the largest possible value is 2839.
- R4: env_valid_o is high for exactly one cycle, two rising clock edges after the edge that accepted the sample (sample_valid_i high).
- R5: After reset the previous-sample magnitude is zero. The first accepted sample produces no env_valid_o pulse, and the second sample pairs with the first.
- R6: Cycles with sample_valid_i low do not alter the stored previous sample, whatever sample_code_i carries.
- R7: Back-to-back accepted samples produce back-to-back envelope outputs, one per input, each with the R3 value.
- R8: env_o keeps its last value in every cycle without a new result.
- R9: During and right after reset, env_valid_o is 0 and env_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Input sample strobe |
| sample_code_i | input | 8 | Companded sample: sign, 3-bit exponent, 4-bit mantissa |
| env_valid_o | output | 1 | Envelope sample strobe |
| env_o | output | 12 | Unsigned envelope |

## Verification
The main function is tried with four kinds of input.
- A fixed stream of hand-computed pairs covers zero against zero, the smallest and largest magnitudes alone and together, codes that differ only in sign, and a pair with one large and one small value. These show whether the expansion, the pairing order and the final scaling are right.
- A sweep of each exponent with a full mantissa, paired with zero, isolates the decoding curve segment by segment.
- A long back-to-back pseudo-random stream, compared against an independent model, separates correct per-cycle pairing from designs that pair with a stale or skipped sample.
- Directed gaps filled with changing codes while the strobe is low separate real sample acceptance from simple sampling on every clock.

// File: rtl/env_lut_pkg.sv
package env_lut_pkg;

  localparam int unsigned DEF_EXP_W  = 3;
  localparam int unsigned DEF_MANT_W = 4;
  localparam int unsigned DEF_OUT_W  = 12;

  // companded magnitude -> linear, segment bias 2^(mant_w+1)+1
  function automatic logic [63:0] mag_expand(input logic [63:0] e, input logic [63:0] m,
                                             input int unsigned mant_w);
    logic [63:0] bias;
    bias = (64'd1 << (mant_w + 1)) + 64'd1;
    return (((m << 1) + bias) << e) - bias;
  endfunction

  // floor square root, bit-serial trial
  function automatic logic [63:0] isqrt(input logic [63:0] v, input int unsigned root_w);
    logic [63:0] r;
    logic [63:0] t;
    r = '0;
    for (int b = int'(root_w) - 1; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  // envelope for one {cur, prev} magnitude address
  function automatic logic [63:0] env_entry(input logic [63:0] addr, input int unsigned exp_w,
                                            input int unsigned mant_w, input int unsigned shift);
    int unsigned mag_w;
    logic [63:0] mmask, emask, a, b, m_a, m_b;
    mag_w = exp_w + mant_w;
    mmask = (64'd1 << mant_w) - 64'd1;
    emask = (64'd1 << exp_w) - 64'd1;
    m_a   = (addr >> mag_w) & ((64'd1 << mag_w) - 64'd1);
    m_b   = addr & ((64'd1 << mag_w) - 64'd1);
    a = mag_expand((m_a >> mant_w) & emask, m_a & mmask, mant_w);
    b = mag_expand((m_b >> mant_w) & emask, m_b & mmask, mant_w);
    return isqrt(a * a + b * b, mant_w + 2 + (1 << exp_w)) >> shift;
  endfunction

endpackage

// File: rtl/env_pair_addr.sv
module env_pair_addr #(
  parameter int unsigned MAG_W  = 7,
  parameter int unsigned CODE_W = MAG_W + 1,
  parameter int unsigned ADDR_W = 2 * MAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] sample_code_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [MAG_W-1:0]  mag;
  logic [MAG_W-1:0]  prev_q;
  logic              first_q;
  logic              addr_valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unused_sign;

  assign mag         = sample_code_i[MAG_W-1:0];
  assign unused_sign = sample_code_i[CODE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      first_q      <= 1'b1;
      addr_valid_q <= 1'b0;
      addr_q       <= '0;
    end else begin
      addr_valid_q <= sample_valid_i & ~first_q;
      if (sample_valid_i) begin
        prev_q  <= mag;
        first_q <= 1'b0;
        addr_q  <= {mag, prev_q};
      end
    end
  end

  assign addr_valid_o = addr_valid_q;
  assign addr_o       = addr_q;

  // R5: first accepted sample after reset yields no address strobe
  a_r5_first_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && sample_valid_i) |=> !addr_valid_o);

  // R6: previous magnitude only moves on an accepted sample
  a_r6_prev_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(prev_q));

  // R4: address strobe needs an accepted sample one edge earlier
  a_r4_addr_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !addr_valid_o);

endmodule

// File: rtl/env_mag_square.sv
module env_mag_square #(
  parameter int unsigned EXP_W  = 3,
  parameter int unsigned MANT_W = 4,
  parameter int unsigned MAG_W  = EXP_W + MANT_W,
  parameter int unsigned LIN_W  = MANT_W + 1 + (1 << EXP_W)
) (
  input  logic [MAG_W-1:0]   mag_i,
  output logic [LIN_W-1:0]   lin_o,
  output logic [2*LIN_W-1:0] sq_o
);

  assign lin_o = LIN_W'(env_lut_pkg::mag_expand(64'(mag_i[MAG_W-1:MANT_W]),
                                                64'(mag_i[MANT_W-1:0]), MANT_W));
  assign sq_o  = (2*LIN_W)'(lin_o) * (2*LIN_W)'(lin_o);

endmodule

// File: rtl/env_table.sv
module env_table #(
  parameter int unsigned EXP_W    = 3,
  parameter int unsigned MANT_W   = 4,
  parameter int unsigned OUT_W    = 12,
  parameter bit          FULL_ROM = 1'b0,
  parameter int unsigned MAG_W    = EXP_W + MANT_W,
  parameter int unsigned ADDR_W   = 2 * MAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              env_valid_o,
  output logic [OUT_W-1:0]  env_o
);

  localparam int unsigned LIN_W  = MANT_W + 1 + (1 << EXP_W);
  localparam int unsigned SUM_W  = 2 * LIN_W + 1;
  localparam int unsigned ROOT_W = LIN_W + 1;
  localparam int unsigned SHIFT  = ROOT_W - OUT_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam logic [63:0] MAX_ENV =
    env_lut_pkg::env_entry((64'd1 << ADDR_W) - 64'd1, EXP_W, MANT_W, SHIFT);

  logic [OUT_W-1:0] env_d;
  logic [OUT_W-1:0] env_q;
  logic             valid_q;

  generate
    if (FULL_ROM) begin : g_rom
      logic [OUT_W-1:0] rom [DEPTH];
      for (genvar i = 0; i < int'(DEPTH); i++) begin : g_ent
        assign rom[i] = OUT_W'(env_lut_pkg::env_entry(64'(i), EXP_W, MANT_W, SHIFT));
      end
      assign env_d = rom[addr_i];
    end else begin : g_fact
      logic [LIN_W-1:0]   lin [2];
      logic [2*LIN_W-1:0] sq  [2];
      logic [SUM_W-1:0]   sum;
      logic [ROOT_W-1:0]  root;
      for (genvar g = 0; g < 2; g++) begin : g_half
        env_mag_square #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_sq (
          .mag_i (addr_i[g*MAG_W +: MAG_W]),
          .lin_o (lin[g]),
          .sq_o  (sq[g])
        );
      end
      assign sum   = SUM_W'(sq[0]) + SUM_W'(sq[1]);
      assign root  = ROOT_W'(env_lut_pkg::isqrt(64'(sum), ROOT_W));
      assign env_d = OUT_W'(root >> SHIFT);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      env_q   <= '0;
    end else begin
      valid_q <= addr_valid_i;
      if (addr_valid_i) env_q <= env_d;
    end
  end

  assign env_valid_o = valid_q;
  assign env_o       = env_q;

  // R8: output register holds without a new address
  a_r8_env_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> $stable(env_o));

  // R3: result never exceeds the full-scale envelope
  a_r3_env_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_valid_o |-> (64'(env_o) <= MAX_ENV));

endmodule

// File: rtl/env_lut_detector.sv
module env_lut_detector #(
  parameter int unsigned EXP_W    = env_lut_pkg::DEF_EXP_W,
  parameter int unsigned MANT_W   = env_lut_pkg::DEF_MANT_W,
  parameter int unsigned OUT_W    = env_lut_pkg::DEF_OUT_W,
  parameter bit          FULL_ROM = 1'b0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sample_valid_i,
  input  logic [EXP_W+MANT_W:0]          sample_code_i,
  output logic                           env_valid_o,
  output logic [OUT_W-1:0]               env_o
);

  localparam int unsigned MAG_W  = EXP_W + MANT_W;
  localparam int unsigned CODE_W = MAG_W + 1;
  localparam int unsigned ADDR_W = 2 * MAG_W;

  logic              addr_valid;
  logic [ADDR_W-1:0] addr;

  env_pair_addr #(.MAG_W(MAG_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_pair (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_code_i  (sample_code_i),
    .addr_valid_o   (addr_valid),
    .addr_o         (addr)
  );

  env_table #(
    .EXP_W(EXP_W), .MANT_W(MANT_W), .OUT_W(OUT_W), .FULL_ROM(FULL_ROM),
    .MAG_W(MAG_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_valid_i (addr_valid),
    .addr_i       (addr),
    .env_valid_o  (env_valid_o),
    .env_o        (env_o)
  );

  // R4: every address strobe becomes an output strobe one edge later
  a_r4_out_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid |=> env_valid_o);

  // R4: no output strobe without an address strobe one edge earlier
  a_r4_out_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid |=> !env_valid_o);

  // R7: an output strobe lasts one cycle unless a new address arrived
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_valid_o && !addr_valid) |=> !env_valid_o);

endmodule

// File: tb/env_lut_detector_tb.sv
module env_lut_detector_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [7:0]  sample_code_i = '0;
  logic        env_valid_o;
  logic [11:0] env_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  env_lut_detector u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_code_i  (sample_code_i),
    .env_valid_o    (env_valid_o),
    .env_o          (env_o)
  );

  // {code, expect_valid, expect_env}, walked with one idle cycle per sample
  localparam int NVEC = 11;
  localparam logic [20:0] VEC [NVEC] = '{
    {8'h0F, 1'b0, 12'd0},
    {8'h00, 1'b1, 12'd7},
    {8'h7F, 1'b1, 12'd2007},
    {8'hFF, 1'b1, 12'd2839},
    {8'h10, 1'b1, 12'd2007},
    {8'h8F, 1'b1, 12'd11},
    {8'h70, 1'b1, 12'd1047},
    {8'h00, 1'b1, 12'd1047},
    {8'h00, 1'b1, 12'd0},
    {8'h83, 1'b1, 12'd1},
    {8'h04, 1'b1, 12'd2}
  };

  function automatic int lin_of(input logic [7:0] c);
    int e, m;
    e = int'(c[6:4]);
    m = int'(c[3:0]);
    return ((2 * m + 33) << e) - 33;
  endfunction

  function automatic int env_of(input logic [7:0] cur, input logic [7:0] prv);
    longint s;
    int r;
    s = longint'(lin_of(cur)) * lin_of(cur) + longint'(lin_of(prv)) * lin_of(prv);
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      if (longint'(r | (1 << b)) * longint'(r | (1 << b)) <= s) r = r | (1 << b);
    end
    return r >> 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sample_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive at N0, drop at N1, sample result at N2
  task automatic send(input logic [7:0] c, output bit v, output int e);
    @(negedge clk_i);
    sample_valid_i = 1'b1;
    sample_code_i  = c;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    @(negedge clk_i);
    v = env_valid_o;
    e = int'(env_o);
  endtask

  initial begin
    bit v;
    int e, held;
    logic [7:0] codes [26];
    logic [15:0] lfsr;

    // R9: reset state
    @(negedge clk_i);
    check(env_valid_o == 1'b0, "R9 valid in reset", int'(env_valid_o), 0);
    check(env_o == 12'd0, "R9 env in reset", int'(env_o), 0);
    do_reset();
    @(negedge clk_i);
    check(env_valid_o == 1'b0 && env_o == 12'd0, "R9 after reset", int'(env_o), 0);

    // R3 R1 R5: vector walk
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][20:13], v, e);
      check(v == VEC[i][12], "R5 R4 vector valid", int'(v), int'(VEC[i][12]));
      if (VEC[i][12]) check(e == int'(VEC[i][11:0]), "R3 vector env", e, int'(VEC[i][11:0]));
    end

    // R8: hold after the pulse
    held = int'(env_o);
    @(negedge clk_i);
    check(env_valid_o == 1'b0, "R4 pulse one cycle", int'(env_valid_o), 0);
    check(int'(env_o) == held, "R8 env hold", int'(env_o), held);

    // R2: exponent sweep, full mantissa, paired with zero
    for (int x = 0; x < 8; x++) begin
      send(8'h00, v, e);
      send({1'b0, 3'(x), 4'hF}, v, e);
      check(v && e == (((63 << x) - 33) >> 2), "R2 segment", e, ((63 << x) - 33) >> 2);
    end

    // R1: sign-only difference
    send(8'h23, v, e);
    send(8'h45, v, e);
    held = e;
    send(8'hA3, v, e);
    send(8'hC5, v, e);
    check(e == held && e == env_of(8'h45, 8'h23), "R1 sign ignored", e, held);

    // R5: reset mid-run, first sample suppressed, second pairs with it
    do_reset();
    send(8'h7F, v, e);
    check(v == 1'b0, "R5 first suppressed", int'(v), 0);
    send(8'h00, v, e);
    check(v && e == 2007, "R5 pairs with first", e, 2007);

    // R6: idle cycles with changing codes do not disturb the pairing
    send(8'h70, v, e);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      sample_code_i = 8'(8'h3C + 8'(k * 17));
    end
    send(8'h00, v, e);
    check(v && e == 1047, "R6 idle ignored", e, 1047);

    // R4: exact two-edge latency
    @(negedge clk_i);
    sample_valid_i = 1'b1;
    sample_code_i  = 8'h7F;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    check(env_valid_o == 1'b0, "R4 not at one edge", int'(env_valid_o), 0);
    @(negedge clk_i);
    check(env_valid_o == 1'b1 && env_o == 12'd2007, "R4 at two edges", int'(env_o), 2007);
    @(negedge clk_i);
    check(env_valid_o == 1'b0, "R4 gone at three edges", int'(env_valid_o), 0);

    // R7: back-to-back pseudo-random stream
    lfsr = 16'hACE1;
    codes[0] = 8'h7F;
    for (int i = 1; i < 26; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      codes[i] = lfsr[7:0];
    end
    for (int i = 1; i < 28; i++) begin
      @(negedge clk_i);
      if (i >= 3) begin
        check(env_valid_o == 1'b1, "R7 stream valid", int'(env_valid_o), 1);
        check(int'(env_o) == env_of(codes[i-2], codes[i-3]), "R7 stream env",
              int'(env_o), env_of(codes[i-2], codes[i-3]));
      end
      sample_valid_i = (i < 26);
      if (i < 26) sample_code_i = codes[i];
    end
    @(negedge clk_i);
    sample_valid_i = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule